// File: doc/BRIEF.md
# Power-State Sequencer

This block holds the power state of a serial memory device and decides when its command engine may accept a transaction. It starts every power-on in a timed lockout. Only after that window does it reach standby. A sleep opcode sends it through a timed entry window into a low-power state. In that state only the wake opcode is honoured, and it leads through a timed exit window back to standby.

The command engine decodes each opcode and gives one strobe for sleep, one for wake, or one for any other opcode, while the chip select is low. A decoded opcode does not act until chip select goes high again. The sequencer drives three outputs: a ready flag that the command engine uses to gate command acceptance, a regulator enable, and a state code. All windows are counted in system-clock cycles set by parameters. A power-on reset always restarts at the lockout, even if the device was asleep.

Top module: `pwr_seq_ctl`

## Requirements
- R1: While reset is held and after its release, `pstate` is 0 (lockout), `ready` is 0 and `reg_en` is 1. This lasts exactly LOCK_CYC clock cycles, and then `pstate` becomes 1 (standby) with `ready` at 1.
- R2: Chip-select activity and command strobes during the lockout are ignored. The lockout keeps its length and ends in standby.
- R3: A sleep strobe in standby takes effect only when chip select rises. The state stays at 1 while chip select is low. It changes to 2 (entering sleep) CS_SYNC+1 cycles after the rise, with `ready` at 0 and `reg_en` at 0.
- R4: The entering-sleep state lasts exactly ENTRY_CYC cycles and then moves to 3 (sleep). `reg_en` stays 0 throughout.
- R5: Commands issued during the entering-sleep window are ignored, and the sequence still completes into sleep.
- R6: In sleep, sleep strobes and other-opcode strobes are ignored. The state stays at 3 and `ready` stays 0.
- R7: A wake strobe in sleep moves the state to 4 (waking) CS_SYNC+1 cycles after chip select rises. Waking lasts exactly EXIT_CYC cycles with `reg_en` at 1 and `ready` at 0, and then the state returns to standby.
- R8: Chip-select activity and strobes during the waking window are not served. `ready` stays 0, the window keeps its length, and the state then becomes standby.
- R9: In standby, wake strobes and other-opcode strobes leave the state at 1.
- R10: A reset while asleep restarts at lockout and then reaches standby, not sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| cs_n | input | 1 | Active-low chip select of the serial port |
| cmd_sleep | input | 1 | One-cycle strobe: sleep opcode decoded |
| cmd_wake | input | 1 | One-cycle strobe: wake opcode decoded |
| cmd_other | input | 1 | One-cycle strobe: any other opcode decoded |
| ready | output | 1 | High only in standby; gates command acceptance |
| reg_en | output | 1 | Regulator enable; low while entering sleep and in sleep |
| pstate | output | 3 | State code: 0 lockout, 1 standby, 2 entering sleep, 3 sleep, 4 waking |

## Verification
The hardest case to reach is a full transaction that lands inside one of the timed windows: a frame during lockout, during sleep entry, or during the wake exit. The window must keep its exact length, and no command may be left armed to fire later. The bench shortens the windows through parameters. It runs the window-length measurement concurrently with a complete chip-select frame carrying strobes, so the frame falls inside the window. It then checks both the measured cycle count and the state reached a few cycles after the window closes.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   typedef enum logic [2:0] {
      PS_LOCK    = 3'd0,
      PS_IDLE    = 3'd1,
      PS_DOZE_IN = 3'd2,
      PS_DOZE    = 3'd3,
      PS_RISE    = 3'd4
   } pstate_t;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= 1'b1;
            else        ff <= d;
         end
         assign q = ff;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else        ff <= {ff[STAGES-2:0], d};
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pwr_seq_arm.sv
module pwr_seq_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic stb_sleep,
   input  logic stb_wake,
   input  logic stb_other,
   input  logic ok_sleep,
   input  logic ok_wake,
   output logic go_sleep,
   output logic go_wake
);
   logic cs_q;
   logic arm_sleep;
   logic arm_wake;
   logic rise;

   assign rise = cs_n && !cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q      <= 1'b1;
         arm_sleep <= 1'b0;
         arm_wake  <= 1'b0;
      end else begin
         cs_q <= cs_n;
         if (rise) begin
            arm_sleep <= 1'b0;
            arm_wake  <= 1'b0;
         end else if (stb_sleep || stb_wake || stb_other) begin
            arm_sleep <= stb_sleep && ok_sleep;
            arm_wake  <= stb_wake && ok_wake;
         end
      end
   end

   assign go_sleep = rise && arm_sleep;
   assign go_wake  = rise && arm_wake;

   // R3: a committed command is consumed and cannot fire twice
   p_commit_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (go_sleep || go_wake) |=> !(go_sleep || go_wake));
   // R6: sleep and wake requests are never committed together
   p_go_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(go_sleep && go_wake));
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         done
);
   logic [W-1:0] cnt;

   assign done = (cnt == limit - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (!done) cnt <= cnt + W'(1);
   end

   // R4: the window counter never runs past the selected length
   p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < limit);
endmodule

// File: rtl/pwr_seq_ctl.sv
module pwr_seq_ctl
   import pwr_seq_pkg::*;
#(
   parameter int LOCK_CYC  = 40000,
   parameter int ENTRY_CYC = 300,
   parameter int EXIT_CYC  = 40000,
   parameter int CS_SYNC   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       cmd_sleep,
   input  logic       cmd_wake,
   input  logic       cmd_other,
   output logic       ready,
   output logic       reg_en,
   output logic [2:0] pstate
);
   localparam int MAX_A = (LOCK_CYC > EXIT_CYC) ? LOCK_CYC : EXIT_CYC;
   localparam int MAX_C = (MAX_A > ENTRY_CYC) ? MAX_A : ENTRY_CYC;
   localparam int CW    = $clog2(MAX_C + 1);

   initial begin
      assert (LOCK_CYC >= 1)  else $error("LOCK_CYC must be at least 1");
      assert (ENTRY_CYC >= 1) else $error("ENTRY_CYC must be at least 1");
      assert (EXIT_CYC >= 1)  else $error("EXIT_CYC must be at least 1");
      assert (CS_SYNC >= 0 && CS_SYNC <= 3) else $error("CS_SYNC out of range");
   end

   pstate_t       st, nxt;
   logic          cs_s;
   logic          go_sleep, go_wake;
   logic          t_done;
   logic [CW-1:0] t_limit;

   pwr_seq_sync #(.STAGES(CS_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s)
   );

   pwr_seq_arm u_arm (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_s),
      .stb_sleep(cmd_sleep), .stb_wake(cmd_wake), .stb_other(cmd_other),
      .ok_sleep(st == PS_IDLE), .ok_wake(st == PS_DOZE),
      .go_sleep(go_sleep), .go_wake(go_wake)
   );

   always_comb begin
      case (st)
         PS_LOCK:    t_limit = CW'(LOCK_CYC);
         PS_DOZE_IN: t_limit = CW'(ENTRY_CYC);
         PS_RISE:    t_limit = CW'(EXIT_CYC);
         default:    t_limit = CW'(1);
      endcase
   end

   pwr_seq_timer #(.W(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(nxt != st),
      .limit(t_limit), .done(t_done)
   );

   always_comb begin
      nxt = st;
      case (st)
         PS_LOCK:    if (t_done)   nxt = PS_IDLE;
         PS_IDLE:    if (go_sleep) nxt = PS_DOZE_IN;
         PS_DOZE_IN: if (t_done)   nxt = PS_DOZE;
         PS_DOZE:    if (go_wake)  nxt = PS_RISE;
         PS_RISE:    if (t_done)   nxt = PS_IDLE;
         default:                  nxt = PS_LOCK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= PS_LOCK;
      else        st <= nxt;
   end

   assign ready  = (st == PS_IDLE);
   assign reg_en = !(st == PS_DOZE_IN || st == PS_DOZE);
   assign pstate = st;

   // R1: lockout ends only when its window has run out
   p_lock_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_IDLE && $past(st) == PS_LOCK) |-> $past(t_done));
   // R3: sleep entry only from standby on a committed sleep opcode
   p_entry_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_DOZE_IN && $past(st) != PS_DOZE_IN) |->
         ($past(st) == PS_IDLE && $past(go_sleep)));
   // R4: sleep is reached only through the entry window
   p_doze_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_DOZE && $past(st) != PS_DOZE) |-> $past(st) == PS_DOZE_IN);
   // R5: the entry window cannot be cut short
   p_entry_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_DOZE_IN && !t_done) |=> st == PS_DOZE_IN);
   // R6: sleep is left only by a committed wake opcode
   p_doze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_DOZE && !go_wake) |=> st == PS_DOZE);
   // R7: waking starts only from sleep on a committed wake opcode
   p_rise_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_RISE && $past(st) != PS_RISE) |->
         ($past(st) == PS_DOZE && $past(go_wake)));
   // R8: the wake exit window cannot be cut short
   p_rise_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_RISE && !t_done) |=> st == PS_RISE);
   // R7: ready rises only at the end of lockout or waking
   p_ready_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(st) == PS_LOCK || $past(st) == PS_RISE));
endmodule

// File: tb/pwr_seq_ctl_test.sv
module pwr_seq_ctl_test;
   localparam int LOCK  = 20;
   localparam int ENTRY = 20;
   localparam int EXITW = 25;
   localparam int SYNC  = 2;
   localparam int LAT   = SYNC + 1;

   logic       clk = 1'b0;
   logic       rst_n, cs_n, cmd_sleep, cmd_wake, cmd_other;
   logic       ready, reg_en;
   logic [2:0] pstate;

   int checks = 0;
   int errors = 0;
   bit done   = 0;
   int n_cnt;
   logic rdy_any, en_any, en_all;

   always #4 clk = ~clk;

   pwr_seq_ctl #(.LOCK_CYC(LOCK), .ENTRY_CYC(ENTRY), .EXIT_CYC(EXITW), .CS_SYNC(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_sleep(cmd_sleep),
      .cmd_wake(cmd_wake), .cmd_other(cmd_other),
      .ready(ready), .reg_en(reg_en), .pstate(pstate)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // kind: 0 sleep, 1 wake, 2 other
   task automatic frame(input int kind);
      @(negedge clk) cs_n = 1'b0;
      repeat (LAT) @(negedge clk);
      cmd_sleep = (kind == 0);
      cmd_wake  = (kind == 1);
      cmd_other = (kind == 2);
      @(negedge clk);
      cmd_sleep = 1'b0; cmd_wake = 1'b0; cmd_other = 1'b0;
      repeat (2) @(negedge clk);
      cs_n = 1'b1;
   endtask

   task automatic latency(output int k, input logic [2:0] from);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (pstate == from && k < 20);
   endtask

   task automatic count_state(input logic [2:0] s);
      n_cnt = 0; rdy_any = 1'b0; en_any = 1'b0; en_all = 1'b1;
      while (pstate == s && n_cnt < 1000) begin
         n_cnt++;
         rdy_any = rdy_any | ready;
         en_any  = en_any | reg_en;
         en_all  = en_all & reg_en;
         @(negedge clk);
      end
   endtask

   initial begin
      int k;
      rst_n = 1'b0; cs_n = 1'b1;
      cmd_sleep = 1'b0; cmd_wake = 1'b0; cmd_other = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset state", pstate, 0);
      check("R1 reset ready", ready, 0);
      check("R1 reset reg_en", reg_en, 1);
      rst_n = 1'b1;
      count_state(3'd0);
      check("R1 lockout length", n_cnt, LOCK);
      check("R1 standby state", pstate, 1);
      check("R1 standby ready", ready, 1);

      frame(1); repeat (6) @(negedge clk);
      check("R9 wake in standby", pstate, 1);
      frame(2); repeat (6) @(negedge clk);
      check("R9 other in standby", pstate, 1);

      @(negedge clk) cs_n = 1'b0;
      repeat (LAT) @(negedge clk);
      cmd_sleep = 1'b1;
      @(negedge clk) cmd_sleep = 1'b0;
      repeat (4) @(negedge clk);
      check("R3 no action while selected", pstate, 1);
      cs_n = 1'b1;
      latency(k, 3'd1);
      check("R3 commit latency", k, LAT);
      check("R3 entering state", pstate, 2);
      check("R3 ready low", ready, 0);
      check("R3 reg_en low", reg_en, 0);

      fork
         count_state(3'd2);
         begin frame(1); frame(0); end
      join
      check("R4 entry length", n_cnt, ENTRY);
      check("R4 reg_en low in entry", en_any, 0);
      check("R5 completes into sleep", pstate, 3);
      repeat (LAT + 2) @(negedge clk);
      check("R5 no late wake", pstate, 3);

      frame(0); repeat (6) @(negedge clk);
      check("R6 sleep in sleep", pstate, 3);
      frame(2); repeat (6) @(negedge clk);
      check("R6 other in sleep", pstate, 3);
      check("R6 ready low in sleep", ready, 0);

      frame(1);
      latency(k, 3'd3);
      check("R7 wake latency", k, LAT);
      check("R7 waking state", pstate, 4);
      count_state(3'd4);
      check("R7 exit length", n_cnt, EXITW);
      check("R7 ready low in exit", rdy_any, 0);
      check("R7 reg_en high in exit", en_all, 1);
      check("R7 back to standby", pstate, 1);

      frame(0);
      repeat (LAT + ENTRY + 2) @(negedge clk);
      check("R8 asleep again", pstate, 3);
      frame(1);
      latency(k, 3'd3);
      fork
         count_state(3'd4);
         begin
            cs_n = 1'b0;
            repeat (LAT) @(negedge clk);
            cmd_sleep = 1'b1;
            @(negedge clk) cmd_sleep = 1'b0;
            repeat (5) @(negedge clk);
            cs_n = 1'b1;
         end
      join
      check("R8 exit length unchanged", n_cnt, EXITW);
      check("R8 ready low in exit", rdy_any, 0);
      repeat (LAT + 2) @(negedge clk);
      check("R8 standby after exit", pstate, 1);

      frame(0);
      repeat (LAT + ENTRY + 2) @(negedge clk);
      check("R10 asleep before reset", pstate, 3);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      fork
         count_state(3'd0);
         begin frame(0); frame(1); end
      join
      check("R2 lockout length with traffic", n_cnt, LOCK);
      check("R10 standby after reset", pstate, 1);
      repeat (LAT + 3) @(negedge clk);
      check("R2 nothing armed in lockout", pstate, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule